// File: doc/BRIEF.md
# Shared Width-Converting I/O and DMA Engine

This block sits between a 32-bit system bus and a 16-bit peripheral bus. It serves two kinds of work. The first is a programmed access, which reads or writes the engine's own registers or a device on the peripheral bus. The second is a DMA burst for one of several channels. The engine owns a single datapath, so it runs exactly one task at a time. A fixed-priority arbiter picks the next task whenever the engine is idle.

Each channel has a fixed direction and a fixed burst length of one to four longwords, both set by parameters. A transmit burst first reads every longword of the burst from memory into four data slots. It then hands each longword to the device as two 16-bit halves, low half first. A receive burst takes two halves from the device, low half first, joins them into a longword and writes that longword to memory. It repeats this for each longword of the burst.

Each channel keeps its own address pointer. The pointer moves forward by four bytes per longword, once, after the whole burst has finished. A sticky per-channel flag is raised when that move takes the pointer into a different 4 KB page. Software clears the flag by writing 1 to it.

State machine: `ST_IDLE`, `ST_PIO_REG`, `ST_PIO_DEV`, `ST_TX_FETCH`, `ST_TX_SEND`, `ST_RX_RECV`, `ST_RX_STORE`, `ST_ADVANCE`. Transitions:
- IDLE goes to TX_FETCH or RX_RECV when a DMA request is granted, depending on the granted channel's direction.
- IDLE goes to PIO_DEV or PIO_REG when a programmed access is granted, depending on address bit 7.
- PIO_REG returns to IDLE after one cycle.
- PIO_DEV returns to IDLE on device acknowledge.
- TX_FETCH goes to TX_SEND on the memory acknowledge of the last longword.
- TX_SEND goes to ADVANCE on the device acknowledge of the last high half.
- RX_RECV goes to RX_STORE on the device acknowledge of a high half.
- RX_STORE goes back to RX_RECV on memory acknowledge, or to ADVANCE after the last longword.
- ADVANCE returns to IDLE after one cycle.

Top module: `wconv_dma_engine`

## Requirements
- R1: After reset the engine is idle. No strobe, request, acknowledge, done pulse or flag is active, and every pointer reads 0.
- R2: A programmed access with address bit 7 = 0 reaches the register file. The word index is address bits 6:2. Index c < 4 reads and writes channel c's 32-bit pointer. Any other index except 31 reads 0 and ignores writes. `pio_ack` is high in the first cycle after the grant.
- R3: A programmed access with address bit 7 = 1 drives a device cycle with `io_dma`=0, `io_addr` = address bits 6:0 and `io_wdata` = `pio_wdata[15:0]`. The cycle holds until `io_ack`, and `pio_ack` comes in that same cycle. A read returns `{16'h0, io_rdata}`.
- R4: Only one task is active at a time. Memory requests appear only during DMA. A programmed device cycle never overlaps a memory request, and `pio_ack` never coincides with DMA traffic.
- R5: DMA has priority over programmed access. Among channels, the lower index wins. A request that loses stays pending until the engine is idle again and is then served.
- R6: Default channels: channel 0 transmits 1 longword, channel 1 transmits 2, channel 2 receives 3, and channel 3 receives 4.
- R7: A transmit burst of N reads pointer+4k for k = 0..N-1, all before the first device write. It then writes 2N halves with `io_dma`=1 and `io_addr` = channel index, in the order low half then high half of each longword.
- R8: A receive burst reads 2N halves from the device (`io_dma`=1, `io_we`=0). It writes `{second half, first half}` for longword k to pointer+4k once both halves of that longword have arrived.
- R9: At the end of a burst, `dma_done[c]` pulses for one cycle and the pointer advances by 4N exactly once. The pointer changes at no other time except a register write.
- R10: Flag c (`irq_flags[c]`, also at index 31 bit c) is set when the advance changes pointer bits 31:12. The flag stays set through later bursts.
- R11: A write to index 31 clears each flag whose data bit is 1 and leaves flags whose data bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pio_req | input | 1 | Programmed access request, held until acknowledged |
| pio_we | input | 1 | 1 = write |
| pio_addr | input | ADDR_W | Bit 7 selects device (1) or register file (0) |
| pio_wdata | input | 32 | Write data |
| pio_ack | output | 1 | Access complete |
| pio_rdata | output | 32 | Read data, valid with pio_ack |
| dma_req | input | NCH | Per-channel burst request, held until done |
| dma_done | output | NCH | One-cycle burst completion pulse |
| irq_flags | output | NCH | Sticky page-crossing flags |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory handshake complete |
| io_strobe | output | 1 | Peripheral cycle active |
| io_we | output | 1 | 1 = write to device |
| io_dma | output | 1 | 1 = DMA half transfer |
| io_addr | output | ADDR_W-1 | Device register, or channel index during DMA |
| io_wdata | output | 16 | Data to device |
| io_rdata | input | 16 | Data from device |
| io_ack | input | 1 | Peripheral handshake complete |

## Verification
The two functions that can fall in one cycle are a DMA request and a programmed-access request. Two DMA channels requesting together is a second such case. The bench raises both requests on the same clock edge while the engine is idle. It judges the result by completion order: the recorded cycle of `dma_done` must come before the cycle of `pio_ack`, and the lower channel's done must come before the higher one's. The held access is also checked for the correct data once the engine returns to idle.

// File: rtl/wconv_pkg.sv
package wconv_pkg;

    localparam int WORD_W    = 32;
    localparam int HALF_W    = 16;
    localparam int LEN_FLD_W = 3;   // width of one burst-length field
    localparam int PAGE_LSB  = 12;  // 4 KB page

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PIO_REG,
        ST_PIO_DEV,
        ST_TX_FETCH,
        ST_TX_SEND,
        ST_RX_RECV,
        ST_RX_STORE,
        ST_ADVANCE
    } eng_state_t;

    function automatic logic page_changed(input logic [WORD_W-1:0] a,
                                          input logic [WORD_W-1:0] b);
        return a[WORD_W-1:PAGE_LSB] != b[WORD_W-1:PAGE_LSB];
    endfunction

endpackage

// File: rtl/wconv_arb.sv
module wconv_arb #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  dma_req,
    input  logic            pio_req,
    output logic            grant_dma,
    output logic            grant_pio,
    output logic [CH_W-1:0] grant_ch
);

    // Fixed priority: any DMA beats programmed access, lowest channel first.
    always_comb begin
        grant_dma = |dma_req;
        grant_pio = pio_req && !grant_dma;
        grant_ch  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (dma_req[i]) begin
                grant_ch = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/wconv_dbuf.sv
module wconv_dbuf #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_word,
    input  logic                         wr_half,
    input  logic [IDX_W-1:0]             idx,
    input  logic                         hsel,
    input  logic [wconv_pkg::WORD_W-1:0] word_in,
    input  logic [wconv_pkg::HALF_W-1:0] half_in,
    output logic [wconv_pkg::WORD_W-1:0] word_out,
    output logic [wconv_pkg::HALF_W-1:0] half_out
);
    import wconv_pkg::*;

    logic [WORD_W-1:0] slots [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            logic [WORD_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (idx == IDX_W'(g)) begin
                    if (wr_word) begin
                        q <= word_in;
                    end else if (wr_half) begin
                        if (hsel) begin
                            q[WORD_W-1:HALF_W] <= half_in;
                        end else begin
                            q[HALF_W-1:0] <= half_in;
                        end
                    end
                end
            end
            assign slots[g] = q;
        end
    endgenerate

    assign word_out = slots[idx];
    assign half_out = hsel ? word_out[WORD_W-1:HALF_W] : word_out[HALF_W-1:0];

endmodule

// File: rtl/wconv_regs.sv
module wconv_regs #(
    parameter int NCH   = 4,
    parameter int CH_W  = 2,
    parameter int IDX_W = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [wconv_pkg::WORD_W-1:0]     wdata,
    output logic [wconv_pkg::WORD_W-1:0]     rdata,
    input  logic                             adv_en,
    input  logic [CH_W-1:0]                  adv_ch,
    input  logic [wconv_pkg::WORD_W-1:0]     adv_bytes,
    input  logic [CH_W-1:0]                  sel_ch,
    output logic [wconv_pkg::WORD_W-1:0]     sel_ptr,
    output logic [NCH*wconv_pkg::WORD_W-1:0] ptr_flat,
    output logic [NCH-1:0]                   flags
);
    import wconv_pkg::*;

    localparam logic [IDX_W-1:0] FLAG_IDX = '1;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            logic [WORD_W-1:0] ptr_q;
            logic [WORD_W-1:0] ptr_nxt;
            logic              flag_q;
            logic              adv_here;

            assign adv_here = adv_en && (adv_ch == CH_W'(c));
            assign ptr_nxt  = ptr_q + adv_bytes;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q <= '0;
                end else if (adv_here) begin
                    ptr_q <= ptr_nxt;
                end else if (wr_en && idx == IDX_W'(c)) begin
                    ptr_q <= wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (adv_here && page_changed(ptr_q, ptr_nxt)) begin
                    flag_q <= 1'b1;
                end else if (wr_en && idx == FLAG_IDX && wdata[c]) begin
                    flag_q <= 1'b0;
                end
            end

            assign ptr_flat[c*WORD_W +: WORD_W] = ptr_q;
            assign flags[c] = flag_q;
        end
    endgenerate

    assign sel_ptr = ptr_flat[sel_ch*WORD_W +: WORD_W];

    always_comb begin
        rdata = '0;
        if (idx == FLAG_IDX) begin
            rdata = {{(WORD_W-NCH){1'b0}}, flags};
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (idx == IDX_W'(c)) begin
                    rdata = ptr_flat[c*WORD_W +: WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/wconv_dma_engine.sv
module wconv_dma_engine #(
    parameter int                 NCH       = 4,
    parameter int                 ADDR_W    = 8,
    parameter int                 MAX_BURST = 4,
    parameter logic [NCH-1:0]     CH_TX     = 4'b0011,
    parameter logic [3*NCH-1:0]   CH_LEN    = {3'd4, 3'd3, 3'd2, 3'd1}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pio_req,
    input  logic              pio_we,
    input  logic [ADDR_W-1:0] pio_addr,
    input  logic [31:0]       pio_wdata,
    output logic              pio_ack,
    output logic [31:0]       pio_rdata,
    input  logic [NCH-1:0]    dma_req,
    output logic [NCH-1:0]    dma_done,
    output logic [NCH-1:0]    irq_flags,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              io_strobe,
    output logic              io_we,
    output logic              io_dma,
    output logic [ADDR_W-2:0] io_addr,
    output logic [15:0]       io_wdata,
    input  logic [15:0]       io_rdata,
    input  logic              io_ack
);
    import wconv_pkg::*;

    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CNT_W  = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;
    localparam int IDX_W  = ADDR_W - 3;
    localparam int DEV_AW = ADDR_W - 1;

    eng_state_t            state_q, state_d;
    logic [CH_W-1:0]       cur_ch_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  half_q;

    logic                  grant_dma, grant_pio;
    logic [CH_W-1:0]       grant_ch;
    logic [LEN_FLD_W-1:0]  cur_len;
    logic                  last_word;
    logic                  dev_sel;

    logic [WORD_W-1:0]     reg_rdata, sel_ptr, buf_word;
    logic [HALF_W-1:0]     buf_half;
    logic [NCH*WORD_W-1:0] ptr_flat;
    logic                  reg_wr, adv_en, buf_wr_word, buf_wr_half;

    assign cur_len   = CH_LEN[cur_ch_q*LEN_FLD_W +: LEN_FLD_W];
    assign last_word = (cnt_q == CNT_W'(cur_len - 3'd1));
    assign dev_sel   = pio_addr[ADDR_W-1];

    wconv_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .dma_req   (dma_req),
        .pio_req   (pio_req),
        .grant_dma (grant_dma),
        .grant_pio (grant_pio),
        .grant_ch  (grant_ch)
    );

    wconv_regs #(.NCH(NCH), .CH_W(CH_W), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .idx       (pio_addr[ADDR_W-2:2]),
        .wdata     (pio_wdata),
        .rdata     (reg_rdata),
        .adv_en    (adv_en),
        .adv_ch    (cur_ch_q),
        .adv_bytes (32'(cur_len) << 2),
        .sel_ch    (cur_ch_q),
        .sel_ptr   (sel_ptr),
        .ptr_flat  (ptr_flat),
        .flags     (irq_flags)
    );

    wconv_dbuf #(.DEPTH(MAX_BURST), .IDX_W(CNT_W)) u_dbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_word  (buf_wr_word),
        .wr_half  (buf_wr_half),
        .idx      (cnt_q),
        .hsel     (half_q),
        .word_in  (mem_rdata),
        .half_in  (io_rdata),
        .word_out (buf_word),
        .half_out (buf_half)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (grant_dma) begin
                    state_d = CH_TX[grant_ch] ? ST_TX_FETCH : ST_RX_RECV;
                end else if (grant_pio) begin
                    state_d = dev_sel ? ST_PIO_DEV : ST_PIO_REG;
                end
            end
            ST_PIO_REG:  state_d = ST_IDLE;
            ST_PIO_DEV:  if (io_ack) state_d = ST_IDLE;
            ST_TX_FETCH: if (mem_ack && last_word) state_d = ST_TX_SEND;
            ST_TX_SEND:  if (io_ack && half_q && last_word) state_d = ST_ADVANCE;
            ST_RX_RECV:  if (io_ack && half_q) state_d = ST_RX_STORE;
            ST_RX_STORE: if (mem_ack) state_d = last_word ? ST_ADVANCE : ST_RX_RECV;
            ST_ADVANCE:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Burst position: channel, longword index, half select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch_q <= '0;
            cnt_q    <= '0;
            half_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (grant_dma) begin
                        cur_ch_q <= grant_ch;
                    end
                    cnt_q  <= '0;
                    half_q <= 1'b0;
                end
                ST_TX_FETCH: begin
                    if (mem_ack) begin
                        cnt_q <= last_word ? '0 : cnt_q + 1'b1;
                    end
                end
                ST_TX_SEND: begin
                    if (io_ack) begin
                        half_q <= !half_q;
                        if (half_q && !last_word) begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RX_RECV: begin
                    if (io_ack) begin
                        half_q <= !half_q;
                    end
                end
                ST_RX_STORE: begin
                    if (mem_ack && !last_word) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pio_ack     = 1'b0;
        pio_rdata   = '0;
        dma_done    = '0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        io_strobe   = 1'b0;
        io_we       = 1'b0;
        io_dma      = 1'b0;
        io_addr     = '0;
        io_wdata    = '0;
        reg_wr      = 1'b0;
        adv_en      = 1'b0;
        buf_wr_word = 1'b0;
        buf_wr_half = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PIO_REG: begin
                pio_ack   = 1'b1;
                pio_rdata = reg_rdata;
                reg_wr    = pio_we;
            end
            ST_PIO_DEV: begin
                io_strobe = 1'b1;
                io_we     = pio_we;
                io_addr   = pio_addr[ADDR_W-2:0];
                io_wdata  = pio_wdata[HALF_W-1:0];
                pio_ack   = io_ack;
                pio_rdata = {{(WORD_W-HALF_W){1'b0}}, io_rdata};
            end
            ST_TX_FETCH: begin
                mem_req     = 1'b1;
                mem_addr    = sel_ptr + (32'(cnt_q) << 2);
                buf_wr_word = mem_ack;
            end
            ST_TX_SEND: begin
                io_strobe = 1'b1;
                io_we     = 1'b1;
                io_dma    = 1'b1;
                io_addr   = DEV_AW'(cur_ch_q);
                io_wdata  = buf_half;
            end
            ST_RX_RECV: begin
                io_strobe   = 1'b1;
                io_dma      = 1'b1;
                io_addr     = DEV_AW'(cur_ch_q);
                buf_wr_half = io_ack;
            end
            ST_RX_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sel_ptr + (32'(cnt_q) << 2);
                mem_wdata = buf_word;
            end
            ST_ADVANCE: begin
                adv_en   = 1'b1;
                dma_done = NCH'(1) << cur_ch_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/wconv_chk.sv
module wconv_chk #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pio_ack,
    input logic              pio_we,
    input logic [ADDR_W-1:0] pio_addr,
    input logic [31:0]       pio_wdata,
    input logic [NCH-1:0]    dma_done,
    input logic [NCH-1:0]    irq_flags,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              io_strobe,
    input logic              io_we,
    input logic              io_dma,
    input logic [ADDR_W-2:0] io_addr,
    input logic [15:0]       io_wdata,
    input logic              io_ack,
    input logic [NCH*32-1:0] ptr_flat
);

    logic reg_write;
    logic flag_write;
    assign reg_write  = pio_ack && pio_we && !pio_addr[ADDR_W-1];
    assign flag_write = reg_write && (&pio_addr[ADDR_W-2:2]);

    // R4
    pio_vs_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && !io_dma) |-> !mem_req);

    // R4
    ack_outside_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pio_ack |-> (!io_dma && !mem_req));

    // R3
    dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && !io_ack) |=> (io_strobe && $stable(io_addr) && $stable(io_wdata)
                                    && $stable(io_we) && $stable(io_dma)));

    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            // R9
            ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!dma_done[c] && !(reg_write && pio_addr[ADDR_W-2:2] == (ADDR_W-3)'(c)))
                |=> $stable(ptr_flat[c*32 +: 32]));

            // R9
            ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dma_done[c] |=> (ptr_flat[c*32 +: 32] != $past(ptr_flat[c*32 +: 32])));

            // R11
            flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(irq_flags[c]) |-> $past(flag_write && pio_wdata[c]));
        end
    endgenerate

endmodule

bind wconv_dma_engine wconv_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pio_ack   (pio_ack),
    .pio_we    (pio_we),
    .pio_addr  (pio_addr),
    .pio_wdata (pio_wdata),
    .dma_done  (dma_done),
    .irq_flags (irq_flags),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .io_strobe (io_strobe),
    .io_we     (io_we),
    .io_dma    (io_dma),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_ack    (io_ack),
    .ptr_flat  (ptr_flat)
);

// File: tb/wconv_dma_engine_test.sv
module wconv_dma_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pio_req = 1'b0, pio_we = 1'b0;
    logic [7:0]  pio_addr = '0;
    logic [31:0] pio_wdata = '0;
    logic        pio_ack;
    logic [31:0] pio_rdata;
    logic [3:0]  dma_req = '0;
    logic [3:0]  dma_done, irq_flags;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        io_strobe, io_we, io_dma, io_ack;
    logic [6:0]  io_addr;
    logic [15:0] io_wdata, io_rdata;

    always #10 clk = ~clk;   // 50 MHz

    wconv_dma_engine uut (
        .clk(clk), .rst_n(rst_n),
        .pio_req(pio_req), .pio_we(pio_we), .pio_addr(pio_addr), .pio_wdata(pio_wdata),
        .pio_ack(pio_ack), .pio_rdata(pio_rdata),
        .dma_req(dma_req), .dma_done(dma_done), .irq_flags(irq_flags),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .io_strobe(io_strobe), .io_we(io_we), .io_dma(io_dma), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack)
    );

    // ---------------- models and logs ----------------
    int          cyc = 0;
    int          errors = 0, checks = 0;
    int          dev_lat = 0;
    int          wcnt = 0;
    logic [15:0] rx_next = 16'h5A00;
    logic [31:0] mem_arr [1024];

    logic [31:0] mrd_addr [32];
    logic [31:0] mwr_addr [32];
    logic [31:0] mwr_data [32];
    logic [15:0] dwr_data [32];
    logic [6:0]  dwr_addr [32];
    logic        dwr_dma  [32];
    int          mrd_n = 0, mwr_n = 0, dwr_n = 0, drd_n = 0;
    int          last_mrd_cyc = 0, first_dwr_cyc = 0;
    int          done_cyc [4];
    int          ack_cyc = 0, req_cyc = 0;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem_arr[mem_addr[11:2]];
    assign io_ack    = io_strobe && (wcnt >= dev_lat);
    assign io_rdata  = rx_next;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!io_strobe || io_ack) wcnt <= 0;
        else wcnt <= wcnt + 1;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem_arr[mem_addr[11:2]] <= mem_wdata;
                if (mwr_n < 32) begin
                    mwr_addr[mwr_n] = mem_addr;
                    mwr_data[mwr_n] = mem_wdata;
                end
                mwr_n = mwr_n + 1;
            end else begin
                if (mrd_n < 32) mrd_addr[mrd_n] = mem_addr;
                mrd_n = mrd_n + 1;
                last_mrd_cyc = cyc;
            end
        end
        if (io_strobe && io_ack) begin
            if (io_we) begin
                if (dwr_n == 0) first_dwr_cyc = cyc;
                if (dwr_n < 32) begin
                    dwr_data[dwr_n] = io_wdata;
                    dwr_addr[dwr_n] = io_addr;
                    dwr_dma[dwr_n]  = io_dma;
                end
                dwr_n = dwr_n + 1;
            end else begin
                rx_next <= rx_next + 16'd1;
                drd_n = drd_n + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        mrd_n = 0; mwr_n = 0; dwr_n = 0; drd_n = 0;
    endtask

    task automatic pio(input logic we, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
        @(negedge clk);
        pio_we = we; pio_addr = a; pio_wdata = d; pio_req = 1'b1;
        req_cyc = cyc;
        do @(negedge clk); while (!pio_ack);
        rd = pio_rdata;
        ack_cyc = cyc;
        @(posedge clk); #1;
        pio_req = 1'b0;
    endtask

    task automatic reg_wr(input int idx, input logic [31:0] d);
        logic [31:0] tmp;
        pio(1'b1, 8'(idx * 4), d, tmp);
    endtask

    task automatic reg_rd(input int idx, output logic [31:0] rd);
        pio(1'b0, 8'(idx * 4), 32'h0, rd);
    endtask

    task automatic dma(input int c);
        @(negedge clk);
        dma_req[c] = 1'b1;
        do @(negedge clk); while (!dma_done[c]);
        done_cyc[c] = cyc;
        @(posedge clk); #1;
        dma_req[c] = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] rd;
        @(negedge clk);
        chk("R1 strobes idle", {28'h0, io_strobe, mem_req, pio_ack, |dma_done}, 32'h0);
        chk("R1 flags clear", {28'h0, irq_flags}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            reg_rd(c, rd);
            chk("R1 pointer zero", rd, 32'h0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] rd;
        for (int c = 0; c < 4; c++) reg_wr(c, 32'h1000_0000 + 32'(c) * 32'h100);
        for (int c = 0; c < 4; c++) begin
            reg_rd(c, rd);
            chk("R2 pointer readback", rd, 32'h1000_0000 + 32'(c) * 32'h100);
        end
        chk("R2 ack one cycle after grant", 32'(ack_cyc - req_cyc), 32'd1);
        reg_wr(5, 32'hFFFF_FFFF);
        reg_rd(5, rd);
        chk("R2 unused index reads 0", rd, 32'h0);
        reg_rd(0, rd);
        chk("R2 unused write no effect", rd, 32'h1000_0000);
    endtask

    task automatic t_dev();
        logic [31:0] rd;
        logic [15:0] rx_now;
        dev_lat = 2;
        clear_logs();
        pio(1'b1, 8'h85, 32'hDEAD_BEEF, rd);
        chk("R3 one device write", 32'(dwr_n), 32'd1);
        chk("R3 device addr", {25'h0, dwr_addr[0]}, 32'h5);
        chk("R3 device data low half", {16'h0, dwr_data[0]}, 32'h0000_BEEF);
        chk("R3 not dma", {31'h0, dwr_dma[0]}, 32'h0);
        chk("R3 ack waits for device", 32'(ack_cyc - req_cyc), 32'd3);
        @(negedge clk);
        rx_now = rx_next;
        pio(1'b0, 8'h8A, 32'h0, rd);
        chk("R3 device read zero-extended", rd, {16'h0, rx_now});
        chk("R4 no memory traffic on device access", 32'(mrd_n + mwr_n), 32'd0);
        dev_lat = 0;
    endtask

    task automatic t_tx();
        logic [31:0] rd;
        dev_lat = 1;
        mem_arr[32'h100 >> 2] = 32'hA1B2_C3D4;
        mem_arr[32'h104 >> 2] = 32'h1122_3344;
        reg_wr(1, 32'h100);
        clear_logs();
        dma(1);
        chk("R6 R7 ch1 reads two longwords", 32'(mrd_n), 32'd2);
        chk("R7 read addr 0", mrd_addr[0], 32'h100);
        chk("R7 read addr 1", mrd_addr[1], 32'h104);
        chk("R7 four halves", 32'(dwr_n), 32'd4);
        chk("R7 half 0", {16'h0, dwr_data[0]}, 32'hC3D4);
        chk("R7 half 1", {16'h0, dwr_data[1]}, 32'hA1B2);
        chk("R7 half 2", {16'h0, dwr_data[2]}, 32'h3344);
        chk("R7 half 3", {16'h0, dwr_data[3]}, 32'h1122);
        chk("R7 dma tag and channel", {24'h0, dwr_dma[3], dwr_addr[3]}, {24'h0, 1'b1, 7'd1});
        chk("R7 fetch before send", 32'(last_mrd_cyc < first_dwr_cyc), 32'd1);
        reg_rd(1, rd);
        chk("R9 ch1 pointer +8", rd, 32'h108);
        dev_lat = 0;
        mem_arr[32'h40 >> 2] = 32'hCAFE_F00D;
        reg_wr(0, 32'h40);
        clear_logs();
        dma(0);
        chk("R6 ch0 one longword", {16'h0, 8'(mrd_n), 8'(dwr_n)}, {16'h0, 8'd1, 8'd2});
        chk("R7 ch0 halves", {dwr_data[1], dwr_data[0]}, 32'hCAFE_F00D);
        reg_rd(0, rd);
        chk("R9 ch0 pointer +4", rd, 32'h44);
    endtask

    task automatic t_rx();
        logic [31:0] rd;
        logic [15:0] b;
        reg_wr(3, 32'h200);
        clear_logs();
        @(negedge clk);
        b = rx_next;
        dma(3);
        chk("R6 R8 ch3 four stores", 32'(mwr_n), 32'd4);
        chk("R8 eight halves read", 32'(drd_n), 32'd8);
        for (int k = 0; k < 4; k++) begin
            chk("R8 store addr", mwr_addr[k], 32'h200 + 32'(k) * 4);
            chk("R8 joined data", mwr_data[k],
                {b + 16'(2 * k + 1), b + 16'(2 * k)});
        end
        chk("R8 no memory reads", 32'(mrd_n), 32'd0);
        reg_rd(3, rd);
        chk("R9 ch3 pointer +16", rd, 32'h210);
        chk("R10 no crossing no flag", {28'h0, irq_flags}, 32'h0);
    endtask

    task automatic t_bound();
        logic [31:0] rd;
        reg_wr(2, 32'hFF8);
        dma(2);
        reg_rd(2, rd);
        chk("R9 ch2 pointer +12", rd, 32'h1004);
        reg_rd(31, rd);
        chk("R10 crossing sets flag", rd, 32'h4);
        dma(1);
        chk("R10 flag sticky", {28'h0, irq_flags}, 32'h4);
        reg_wr(31, 32'h0);
        reg_rd(31, rd);
        chk("R11 write 0 keeps flag", rd, 32'h4);
        reg_wr(31, 32'h4);
        reg_rd(31, rd);
        chk("R11 write 1 clears flag", rd, 32'h0);
        reg_wr(3, 32'hFE0);
        dma(3);
        chk("R10 ending below page no flag", {28'h0, irq_flags}, 32'h0);
        dma(3);
        chk("R10 landing on page edge sets flag", {28'h0, irq_flags}, 32'h8);
        reg_wr(31, 32'hF);
        chk("R11 clear ch3 flag", {28'h0, irq_flags}, 32'h0);
    endtask

    task automatic t_arb();
        logic [31:0] rd;
        reg_wr(0, 32'h300);
        fork
            pio(1'b0, 8'h00, 32'h0, rd);
            dma(1);
        join
        chk("R5 dma before programmed access", 32'(done_cyc[1] < ack_cyc), 32'd1);
        chk("R5 held access served", rd, 32'h300);
        fork
            dma(0);
            dma(3);
        join
        chk("R5 lower channel first", 32'(done_cyc[0] < done_cyc[3]), 32'd1);
        reg_rd(0, rd);
        chk("R4 R9 ch0 advanced once", rd, 32'h304);
    endtask

    // ---------------- main ----------------
    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < 1024; i++) mem_arr[i] = 32'(i) * 32'h0101_0101;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_dev();
        t_tx();
        t_rx();
        t_bound();
        t_arb();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule